// File: doc/BRIEF.md
# Programmable High/Low Clock Divider

This block derives a slower clock from a source clock with a counter. The output waveform is not set by a single ratio. It is set by four fields: a high-phase count, a low-phase count, a half-cycle extension flag and a bypass flag. For a division ratio N the fields are normally filled as follows:

- high count = floor(N/2)
- low count = N − high count
- extension flag = N mod 2
- bypass flag set only when N = 1

With these values an odd ratio gives a duty cycle close to 50 %.

The fields arrive in two 16-bit configuration words and are captured on a one-cycle load strobe. A captured setting is held pending. It becomes active only when the output period in progress has finished, so a reprogramming never cuts a phase short. Each count field is six bits wide, and a field value of zero stands for 64. This lets two full phases reach a ratio of 128.

Top module: `clk_hilo_div`

## Requirements
- R1: While `rst_ni` is low, `clk_o` is low. After reset the active setting is high = 1, low = 1, no extension and no bypass, which gives a divide-by-2 waveform.
- R2: Word A (`cfg_a_i`) carries the high count in bits 11:6 and the low count in bits 5:0. Bits 15:12 have no effect on the output.
- R3: Word B (`cfg_b_i`) carries the half-cycle extension flag in bit 7 and the bypass flag in bit 6. All other bits have no effect on the output.
- R4: With extension and bypass clear, `clk_o` rises at a rising edge of `clk_i`. It stays high for the high count of input cycles, then low for the low count, and repeats.
- R5: With extension set and bypass clear, the high phase lasts the high count plus half an input period. The low phase is shorter by the same half period, so the total period is unchanged.
- R6: With bypass set, `clk_o` follows `clk_i`, and the count and extension fields have no effect.
- R7: A count field value of zero means 64, so high = low = 64 gives a ratio of 128.
- R8: A setting loaded on `load_i` takes effect only at the end of the output period in progress. That period completes with its old high and low lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| cfg_a_i | input | 16 | Word A: high count [11:6], low count [5:0] |
| cfg_b_i | input | 16 | Word B: extension flag [7], bypass flag [6] |
| load_i | input | 1 | One-cycle strobe that captures both words |
| clk_o | output | 1 | Divided clock |

## Verification
The bench sweeps every ratio from 1 to 128, encoded exactly as the field rules give. It measures each high and low phase in half input periods. An odd ratio with the extension path missing, or with the extension on the wrong edge, shows up as a phase that is one half-period off. A design that takes a zero field literally would stall or run at a short ratio instead of 128. Some configurations carry junk in the unused bits of both words, so a decoder that looks at the wrong bit positions changes the measured phases. One load is placed in the middle of a long high phase. A design that applies the new setting at once produces a truncated pulse, which the bench reports as a short high phase.

// File: rtl/clkdiv_pkg.sv
// Package: shared field layout, decoded setting type and decode helper for
// the high/low clock divider. Assumes six-bit count fields in 16-bit words.
package clkdiv_pkg;
    localparam int WORD_W    = 16;
    localparam int FLD_W     = 6;
    localparam int CNT_W     = FLD_W + 2;   // holds a period of up to 2*2^FLD_W
    localparam int HI_LSB    = 6;
    localparam int LO_LSB    = 0;
    localparam int HALF_BIT  = 7;
    localparam int BYP_BIT   = 6;

    typedef struct packed {
        logic [FLD_W:0] hi;      // high-phase length, 1..2^FLD_W
        logic [FLD_W:0] lo;      // low-phase length, 1..2^FLD_W
        logic           half;    // extend high phase by half a period
        logic           bypass;  // pass the source clock through
    } div_cfg_t;

    localparam div_cfg_t CFG_RESET = '{hi: 7'd1, lo: 7'd1, half: 1'b0, bypass: 1'b0};

    // A zero field stands for the full count 2^FLD_W
    function automatic logic [FLD_W:0] expand_cnt(input logic [FLD_W-1:0] fld);
        expand_cnt = (fld == '0) ? (FLD_W+1)'(1 << FLD_W) : {1'b0, fld};
    endfunction

    function automatic div_cfg_t decode_cfg(input logic [WORD_W-1:0] wa,
                                            input logic [WORD_W-1:0] wb);
        div_cfg_t c;
        c.hi     = expand_cnt(wa[HI_LSB +: FLD_W]);
        c.lo     = expand_cnt(wa[LO_LSB +: FLD_W]);
        c.half   = wb[HALF_BIT];
        c.bypass = wb[BYP_BIT];
        decode_cfg = c;
    endfunction
endpackage

// File: rtl/div_cfg_stage.sv
// Configuration stage: captures both words on a load strobe into a pending
// slot and promotes the pending setting to active only at a period boundary.
// Assumes wrap_i is high on the last input cycle of each output period.
module div_cfg_stage
    import clkdiv_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [WORD_W-1:0] cfg_a_i,
    input  logic [WORD_W-1:0] cfg_b_i,
    input  logic              load_i,
    input  logic              wrap_i,
    output div_cfg_t          act_o,
    output logic              pend_vld_o
);
    div_cfg_t pend_q;
    div_cfg_t act_q;
    logic     pend_vld_q;

    // Pending slot: the latest load overwrites any earlier unapplied one
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pend_q <= CFG_RESET;
        end else if (load_i) begin
            pend_q <= decode_cfg(cfg_a_i, cfg_b_i);
        end
    end

    // Pending flag: set by a load, cleared when the setting is promoted
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pend_vld_q <= 1'b0;
        end else if (load_i) begin
            pend_vld_q <= 1'b1;
        end else if (wrap_i) begin
            pend_vld_q <= 1'b0;
        end
    end

    // Active setting: changes only at the end of a complete output period
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            act_q <= CFG_RESET;
        end else if (wrap_i && pend_vld_q) begin
            act_q <= pend_q;
        end
    end

    assign act_o      = act_q;
    assign pend_vld_o = pend_vld_q;
endmodule

// File: rtl/div_period_cnt.sv
// Period counter: walks an index through one output period and drives the
// registered high phase. Assumes hi and lo of the active setting are >= 1.
module div_period_cnt
    import clkdiv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  div_cfg_t         cfg_i,
    output logic             wrap_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] len_o,
    output logic             hi_o
);
    localparam logic [CNT_W-1:0] RST_LAST =
        CNT_W'(CFG_RESET.hi) + CNT_W'(CFG_RESET.lo) - CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] len;
    logic             hi_q;

    // Period length and end-of-period detection
    always_comb begin
        len     = CNT_W'(cfg_i.hi) + CNT_W'(cfg_i.lo);
        cnt_nxt = cnt_q + CNT_W'(1);
        wrap_o  = cfg_i.bypass || (cnt_q == len - CNT_W'(1));
    end

    // Index and high-phase register; a new period always starts high
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= RST_LAST;
            hi_q  <= 1'b0;
        end else if (wrap_o) begin
            cnt_q <= '0;
            hi_q  <= 1'b1;
        end else begin
            cnt_q <= cnt_nxt;
            hi_q  <= (cnt_nxt < CNT_W'(cfg_i.hi));
        end
    end

    assign cnt_o = cnt_q;
    assign len_o = len;
    assign hi_o  = hi_q;
endmodule

// File: rtl/div_half_ext.sv
// Output stage: a falling-edge copy of the high phase stretches it by half an
// input period when requested; bypass selects the source clock directly.
module div_half_ext (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hi_i,
    input  logic half_i,
    input  logic bypass_i,
    output logic clk_o
);
    logic hi_neg_q;

    // Half-period delayed copy of the high phase
    always_ff @(negedge clk_i) begin
        if (!rst_ni) begin
            hi_neg_q <= 1'b0;
        end else begin
            hi_neg_q <= hi_i;
        end
    end

    // Output select: pass-through or stretched high phase
    always_comb begin
        if (bypass_i) begin
            clk_o = clk_i;
        end else begin
            clk_o = hi_i | (half_i & hi_neg_q);
        end
    end
endmodule

// File: rtl/clk_hilo_div.sv
// Top: programmable high/low clock divider. Words are captured on load_i,
// applied at the next period boundary and turned into the output waveform.
// Assumes load_i is synchronous to clk_i.
module clk_hilo_div
    import clkdiv_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [WORD_W-1:0] cfg_a_i,
    input  logic [WORD_W-1:0] cfg_b_i,
    input  logic              load_i,
    output logic              clk_o
);
    div_cfg_t         act;
    logic             pend_vld;
    logic             wrap;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len;
    logic             hi;

    div_cfg_stage u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cfg_a_i    (cfg_a_i),
        .cfg_b_i    (cfg_b_i),
        .load_i     (load_i),
        .wrap_i     (wrap),
        .act_o      (act),
        .pend_vld_o (pend_vld)
    );

    div_period_cnt u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cfg_i  (act),
        .wrap_o (wrap),
        .cnt_o  (cnt),
        .len_o  (len),
        .hi_o   (hi)
    );

    div_half_ext u_out (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .hi_i     (hi),
        .half_i   (act.half),
        .bypass_i (act.bypass),
        .clk_o    (clk_o)
    );
endmodule

// File: rtl/clk_hilo_div_chk.sv
// Checker: temporal properties of the divider, bound to the top module.
module clk_hilo_div_chk
    import clkdiv_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             load_i,
    input logic             wrap,
    input logic             hi,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] len,
    input div_cfg_t         act,
    input logic             pend_vld
);
    // R1: a reset edge leaves the high phase low
    p_reset_low_r1: assert property (@(posedge clk_i) !rst_ni |=> !hi);

    // R8: the active setting never changes inside a period
    p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap |=> $stable(act));

    // R8: a load always leaves a setting pending
    p_load_pending_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> pend_vld);

    // R4: the index stays inside the active period
    p_cnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt < len);

    // R4: each new period opens with the high phase
    p_period_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap |=> hi);

    // R4: the high phase ends exactly after the high count
    p_high_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(hi) |-> (cnt == CNT_W'(act.hi)));
endmodule

bind clk_hilo_div clk_hilo_div_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .wrap     (wrap),
    .hi       (hi),
    .cnt      (cnt),
    .len      (len),
    .act      (act),
    .pend_vld (pend_vld)
);

// File: tb/test_clk_hilo_div.sv
// Bench: sweeps all ratios 1..128 and measures phases in half input periods.
module test_clk_hilo_div;
    localparam int CLK_T    = 20;
    localparam int WD_LIMIT = 190000;

    logic        clk_i;
    logic        rst_ni;
    logic [15:0] cfg_a_i;
    logic [15:0] cfg_b_i;
    logic        load_i;
    logic        clk_o;

    int n_chk;
    int n_bad;
    logic s;

    clk_hilo_div i_clk_hilo_div (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cfg_a_i (cfg_a_i),
        .cfg_b_i (cfg_b_i),
        .load_i  (load_i),
        .clk_o   (clk_o)
    );

    initial begin
        clk_i = 1'b0;
        forever #(CLK_T/2) clk_i = ~clk_i;
    end

    // Watchdog
    initial begin
        repeat (WD_LIMIT) @(posedge clk_i);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    // Advance half an input period and sample the output away from the edge
    task automatic step();
        @(posedge clk_i or negedge clk_i);
        #(CLK_T/4);
        s = clk_o;
    endtask

    task automatic wait_rise();
        logic prev;
        int   k;
        prev = s;
        k = 0;
        step();
        while (!(prev == 1'b0 && s == 1'b1) && k < 2000) begin
            prev = s;
            step();
            k++;
        end
    endtask

    task automatic run_len(input logic v, output int n);
        n = 0;
        while (s == v && n < 2000) begin
            n++;
            step();
        end
    endtask

    task automatic load(input logic [15:0] a, input logic [15:0] b);
        cfg_a_i = a;
        cfg_b_i = b;
        load_i  = 1'b1;
        step();
        step();
        load_i  = 1'b0;
    endtask

    // Load, let it settle, then measure one period
    task automatic apply_measure(input logic [15:0] a, input logic [15:0] b,
                                 input int exp_hi, input int exp_lo,
                                 input string req);
        int h;
        int l;
        load(a, b);
        wait_rise();
        wait_rise();
        run_len(1'b1, h);
        run_len(1'b0, l);
        check({req, " high"}, h, exp_hi);
        check({req, " low"}, l, exp_lo);
    endtask

    initial begin
        int h;
        int l;
        int n;
        n_chk   = 0;
        n_bad   = 0;
        rst_ni  = 1'b0;
        load_i  = 1'b0;
        cfg_a_i = '0;
        cfg_b_i = '0;
        s       = 1'b0;

        // R1: low during reset
        repeat (6) step();
        check("R1 reset level", int'(s), 0);
        rst_ni = 1'b1;

        // R1: reset setting is divide by 2
        wait_rise();
        run_len(1'b1, h);
        run_len(1'b0, l);
        check("R1 reset high", h, 2);
        check("R1 reset low", l, 2);

        // R4 R5 R6 R7 R2 R3: all ratios by the field rules
        for (int r = 1; r <= 128; r++) begin
            int hc;
            int lc;
            int ed;
            logic [15:0] a;
            logic [15:0] b;
            string tag;
            hc = r / 2;
            lc = r - hc;
            ed = r % 2;
            if (r == 1) begin
                hc = 1;
                lc = 1;
            end
            a = 16'((hc % 64) << 6) | 16'(lc % 64);
            b = 16'(ed << 7) | ((r == 1) ? 16'h0040 : 16'h0000);
            if (r % 3 == 0) begin
                a = a | 16'hA000;
                b = b | 16'h5B3F & ~16'h00C0;
            end
            if (r == 1)        tag = "R6 bypass";
            else if (r == 128) tag = "R7 ratio 128";
            else if (ed == 1)  tag = "R5 odd ratio";
            else               tag = "R4 even ratio";
            if (r % 3 == 0) tag = {tag, " R2 R3 junk bits"};
            if (r == 1) apply_measure(a, b, 1, 1, tag);
            else        apply_measure(a, b, 2*(r/2) + ed, 2*(r - r/2) - ed, tag);
        end

        // R5: extension on an even split
        apply_measure(16'h0082, 16'h0080, 5, 3, "R5 even split extended");
        // R4: unequal phases without extension
        apply_measure(16'h00C5, 16'h0000, 6, 10, "R4 unequal phases");
        // R7: zero high field means 64
        apply_measure(16'h0003, 16'h0000, 128, 6, "R7 zero high field");
        // R6: bypass ignores counts and extension
        apply_measure(16'h0147, 16'h00C0, 1, 1, "R6 bypass fields ignored");

        // R8: a load in mid high phase must not cut the period
        apply_measure(16'h028A, 16'h0000, 20, 20, "R8 setup 20");
        wait_rise();
        n = 0;
        repeat (6) begin
            n += int'(s);
            step();
        end
        cfg_a_i = 16'h00C3;
        cfg_b_i = 16'h0000;
        load_i  = 1'b1;
        repeat (2) begin
            n += int'(s);
            step();
        end
        load_i = 1'b0;
        run_len(1'b1, h);
        run_len(1'b0, l);
        check("R8 old high kept", n + h, 20);
        check("R8 old low kept", l, 20);
        run_len(1'b1, h);
        run_len(1'b0, l);
        check("R8 new high", h, 6);
        check("R8 new low", l, 6);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule